// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block sits between the fetch stage and the instruction cache. For each fetch request it takes the fetch program counter together with the result of an instruction TLB lookup made for the same address, and returns the physical address to fetch from, a flag that the access must bypass the cache, and a fault code. The TLB array and the miss handler live outside the block. The block only consumes the lookup result: hit, physical page number and per-mode execute-enable bits.

Several translation paths are chosen in a fixed priority:

1. A program counter with bit 0 set marks privileged code and skips translation.
2. A physical-mode flag passes the address through unchanged.
3. A kernel-only superpage window maps directly to physical space.
4. Every other address goes through the TLB result.

After the path is chosen, the physical address is checked against the implemented range. It is also decoded for the uncached space and for the internal-register space. The result is registered, so each request produces one response one clock later.

Top module: `ifetch_xlate`

## Requirements
- R1: While reset is held low, and until the first request, `rspValid` is 0, `fault` is 0 and `physAddr` is 0.
- R2: A request sampled with `reqValid` high at a rising edge produces `rspValid` high for exactly that following cycle. With no request, `rspValid` is 0.
- R3: When `fetchPc[0]` is 1, `physAddr` is `fetchPc[43:2]` followed by two zero bits, `fault` is 0 and `uncached` is 0. This holds whatever the values of `physMode`, `curMode` and the TLB inputs.
- R4: When `fetchPc[0]` is 0 and `physMode` is 1, `physAddr` equals `fetchPc[43:0]` unchanged, with no TLB use.
- R5: For a translated access (`fetchPc[0]` and `physMode` both 0), `fetchPc[63:47]` must be all zeros or all ones. Otherwise `fault` is 1, the access violation code.
- R6: A translated access whose `fetchPc[47:41]` equals 7'h7E is a superpage access. It faults with code 1 unless `curMode` is 0 (kernel). The mode encoding is 0 kernel, 1 executive, 2 supervisor, 3 user.
- R7: A superpage physical address is `fetchPc[43:0]`, except that bits 43:40 become 4'hF when bit 40 is 1 and become 0 when bit 40 is 0.
- R8: A translated non-superpage access with `tlbHit` 0 gives `fault` 2, the page miss code.
- R9: On a TLB hit, `physAddr` is `{tlbPpn, fetchPc[12:2], 2'b00}`, using an 8 KB page.
- R10: On a TLB hit where `tlbReadEn[curMode]` is 0, `fault` is 1.
- R11: In physical mode, a `fetchPc` with any of bits 63:44 set gives `fault` 3, the machine check code.
- R12: Outside the privileged-code path, a fault-free physical address with bit 43 set drives `uncached` high. If bits 43:28 are also all ones (internal-register space), `fault` is 4, the unimplemented code, instead.
- R13: A response with a nonzero `fault` has `physAddr` 0 and `uncached` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Fetch request present this cycle |
| fetchPc | input | 64 | Fetch virtual address; bit 0 marks privileged code |
| physMode | input | 1 | Use the address as physical without translation |
| curMode | input | 2 | Current mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| tlbHit | input | 1 | TLB lookup for `fetchPc` found an entry |
| tlbPpn | input | 31 | Physical page number from the TLB entry |
| tlbReadEn | input | 4 | Execute-enable bit per mode, indexed by `curMode` |
| rspValid | output | 1 | Response valid |
| physAddr | output | 44 | Translated physical address (0 on a fault) |
| uncached | output | 1 | Access must bypass the cache |
| fault | output | 3 | 0 none, 1 access violation, 2 page miss, 3 machine check, 4 unimplemented |

## Verification
A wrong path selection in the control shows up on the very next response. It appears either as a physical address built from the wrong source or as a fault code that belongs to a different priority level. The directed cases are therefore built so that each path produces an address no other path could produce.

A stuck or mis-decoded range flag shows on the same cycle's response through `uncached` or through a fault code of 3 or 4. Because every request is answered one cycle later and nothing is kept across requests, no error can hide for more than one response.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ACV   = 3'd1,
    FLT_MISS  = 3'd2,
    FLT_MCHK  = 3'd3,
    FLT_UNIMP = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    SRC_PAL   = 2'd0,
    SRC_PHYS  = 2'd1,
    SRC_SUPER = 2'd2,
    SRC_TLB   = 2'd3
  } src_e;

  typedef struct packed {
    logic load;
    src_e src;
  } dpStrobe_t;

endpackage

// File: rtl/ifx_datapath.sv
module ifx_datapath
  import ifx_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 44,
  parameter int PAGE_BITS = 13,
  parameter int SEXT_BIT  = 40,
  parameter int UNC_BIT   = 43,
  parameter int IPR_LO    = 28,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VA_W-1:0]  fetchPc,
  input  logic [PPN_W-1:0] tlbPpn,
  input  dpStrobe_t        strobe,
  input  logic             dropAddr,
  output logic             outOfRange,
  output logic             uncBit,
  output logic             iprHit,
  output logic [PA_W-1:0]  physAddr
);

  localparam int TOP_W = PA_W - SEXT_BIT;

  logic [PA_W-1:0] palPa, physPa, superPa, tlbPa, candPa;

  always_comb begin
    palPa   = {fetchPc[PA_W-1:2], 2'b00};
    physPa  = fetchPc[PA_W-1:0];
    superPa = fetchPc[PA_W-1:0];
    superPa[PA_W-1:SEXT_BIT] = fetchPc[SEXT_BIT] ? {TOP_W{1'b1}} : {TOP_W{1'b0}};
    tlbPa   = {tlbPpn, fetchPc[PAGE_BITS-1:2], 2'b00};
    unique case (strobe.src)
      SRC_PAL:   candPa = palPa;
      SRC_PHYS:  candPa = physPa;
      SRC_SUPER: candPa = superPa;
      default:   candPa = tlbPa;
    endcase
  end

  assign outOfRange = |fetchPc[VA_W-1:PA_W];
  assign uncBit     = candPa[UNC_BIT];
  assign iprHit     = &candPa[PA_W-1:IPR_LO];

  always_ff @(posedge clk) begin
    if (!rstN) physAddr <= '0;
    else if (strobe.load) physAddr <= dropAddr ? '0 : candPa;
  end

endmodule

// File: rtl/ifx_control.sv
module ifx_control
  import ifx_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int SP_LO   = 41,
  parameter logic [VA_IMPL-SP_LO-1:0] SP_TAG = 7'h7E,
  parameter int MODE_W  = 2,
  localparam int EN_W   = 1 << MODE_W,
  localparam int HI_W   = VA_W - VA_IMPL + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   fetchPc,
  input  logic              physMode,
  input  logic [MODE_W-1:0] curMode,
  input  logic              tlbHit,
  input  logic [EN_W-1:0]   tlbReadEn,
  input  logic              outOfRange,
  input  logic              uncBit,
  input  logic              iprHit,
  output dpStrobe_t         strobe,
  output logic              dropAddr,
  output logic              rspValid,
  output logic              uncached,
  output logic [2:0]        fault
);

  logic [HI_W-1:0] vaHigh;
  logic   canonical, superHit, isPal, cacheCheck;
  src_e   srcSel;
  fault_e pathFault, faultNext;

  assign vaHigh    = fetchPc[VA_W-1:VA_IMPL-1];
  assign canonical = (&vaHigh) | ~(|vaHigh);
  assign superHit  = fetchPc[VA_IMPL-1:SP_LO] == SP_TAG;
  assign isPal     = fetchPc[0];

  always_comb begin
    srcSel     = SRC_TLB;
    pathFault  = FLT_NONE;
    cacheCheck = 1'b1;
    if (isPal) begin
      srcSel     = SRC_PAL;
      cacheCheck = 1'b0;
    end else if (physMode) begin
      srcSel = SRC_PHYS;
      if (outOfRange) pathFault = FLT_MCHK;
    end else if (!canonical) begin
      pathFault = FLT_ACV;
    end else if (superHit) begin
      srcSel = SRC_SUPER;
      if (curMode != '0) pathFault = FLT_ACV;
    end else if (!tlbHit) begin
      pathFault = FLT_MISS;
    end else if (!tlbReadEn[curMode]) begin
      pathFault = FLT_ACV;
    end
    faultNext = pathFault;
    if (pathFault == FLT_NONE && cacheCheck && uncBit && iprHit) faultNext = FLT_UNIMP;
  end

  assign strobe   = '{load: reqValid, src: srcSel};
  assign dropAddr = faultNext != FLT_NONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      uncached <= 1'b0;
      fault    <= FLT_NONE;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        fault    <= faultNext;
        uncached <= cacheCheck && uncBit && faultNext == FLT_NONE;
      end
    end
  end

endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
  import ifx_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL   = 48,
  parameter int PA_W      = 44,
  parameter int PAGE_BITS = 13,
  parameter int MODE_W    = 2,
  localparam int PPN_W    = PA_W - PAGE_BITS,
  localparam int EN_W     = 1 << MODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   fetchPc,
  input  logic              physMode,
  input  logic [MODE_W-1:0] curMode,
  input  logic              tlbHit,
  input  logic [PPN_W-1:0]  tlbPpn,
  input  logic [EN_W-1:0]   tlbReadEn,
  output logic              rspValid,
  output logic [PA_W-1:0]   physAddr,
  output logic              uncached,
  output logic [2:0]        fault
);

  dpStrobe_t strobe;
  logic dropAddr, outOfRange, uncBit, iprHit;

  ifx_control #(.VA_W(VA_W), .VA_IMPL(VA_IMPL), .MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fetchPc(fetchPc),
    .physMode(physMode), .curMode(curMode), .tlbHit(tlbHit),
    .tlbReadEn(tlbReadEn), .outOfRange(outOfRange), .uncBit(uncBit),
    .iprHit(iprHit), .strobe(strobe), .dropAddr(dropAddr),
    .rspValid(rspValid), .uncached(uncached), .fault(fault)
  );

  ifx_datapath #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .tlbPpn(tlbPpn),
    .strobe(strobe), .dropAddr(dropAddr), .outOfRange(outOfRange),
    .uncBit(uncBit), .iprHit(iprHit), .physAddr(physAddr)
  );

endmodule

// File: rtl/ifetch_xlate_chk.sv
module ifetch_xlate_chk #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 44,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [VA_W-1:0]   fetchPc,
  input logic              physMode,
  input logic [MODE_W-1:0] curMode,
  input logic              tlbHit,
  input logic              rspValid,
  input logic [PA_W-1:0]   physAddr,
  input logic              uncached,
  input logic [2:0]        fault
);

  logic transl, canon, superWin;
  assign transl   = reqValid && !fetchPc[0] && !physMode;
  assign canon    = (&fetchPc[63:47]) || !(|fetchPc[63:47]);
  assign superWin = fetchPc[47:41] == 7'h7E;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  a_r3_pal_clean: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && fetchPc[0]) |=> (fault == 3'd0 && !uncached && physAddr[1:0] == 2'b00));
  a_r5_noncanon: assert property (@(posedge clk) disable iff (!rstN)
    (transl && !canon) |=> fault == 3'd1);
  a_r6_super_kernel_only: assert property (@(posedge clk) disable iff (!rstN)
    (transl && canon && superWin && curMode != '0) |=> fault == 3'd1);
  a_r8_miss: assert property (@(posedge clk) disable iff (!rstN)
    (transl && canon && !superWin && !tlbHit) |=> fault == 3'd2);
  a_r13_fault_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && fault != 3'd0) |-> (physAddr == '0 && !uncached));
  a_r12_code_range: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> fault <= 3'd4);

endmodule

bind ifetch_xlate ifetch_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .fetchPc(fetchPc),
  .physMode(physMode), .curMode(curMode), .tlbHit(tlbHit),
  .rspValid(rspValid), .physAddr(physAddr), .uncached(uncached), .fault(fault)
);

// File: tb/sim_ifetch_xlate.sv
module sim_ifetch_xlate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] fetchPc = '0;
  logic        physMode = 1'b0;
  logic [1:0]  curMode = '0;
  logic        tlbHit = 1'b0;
  logic [30:0] tlbPpn = '0;
  logic [3:0]  tlbReadEn = '0;
  logic        rspValid;
  logic [43:0] physAddr;
  logic        uncached;
  logic [2:0]  fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ifetch_xlate u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fetchPc(fetchPc),
    .physMode(physMode), .curMode(curMode), .tlbHit(tlbHit), .tlbPpn(tlbPpn),
    .tlbReadEn(tlbReadEn), .rspValid(rspValid), .physAddr(physAddr),
    .uncached(uncached), .fault(fault)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xlate(input string req, input logic [63:0] pc, input logic phys,
                       input logic [1:0] mode, input logic hit, input logic [30:0] ppn,
                       input logic [3:0] ren, input logic [43:0] expPa,
                       input logic expUnc, input logic [2:0] expFault);
    @(negedge clk);
    reqValid = 1'b1; fetchPc = pc; physMode = phys; curMode = mode;
    tlbHit = hit; tlbPpn = ppn; tlbReadEn = ren;
    @(negedge clk);
    reqValid = 1'b0;
    chk({req, " valid"}, 64'(rspValid), 64'd1);
    chk({req, " addr"}, 64'(physAddr), 64'(expPa));
    chk({req, " uncached"}, 64'(uncached), 64'(expUnc));
    chk({req, " fault"}, 64'(fault), 64'(expFault));
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(rspValid), 64'd0);
    chk("R1 reset fault", 64'(fault), 64'd0);
    chk("R1 reset addr", 64'(physAddr), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid", 64'(rspValid), 64'd0);
  endtask

  task automatic testPal();
    xlate("R3 pal low", 64'h0000_0000_1234_5679, 1'b0, 2'd0, 1'b1, 31'd0, 4'hF,
          44'h0_1234_5678, 1'b0, 3'd0);
    xlate("R3 pal ignores mode/tlb/phys", 64'h0000_0ABC_DEF0_1237, 1'b1, 2'd3, 1'b0, 31'd0, 4'h0,
          44'hABC_DEF0_1234, 1'b0, 3'd0);
    xlate("R3 pal high bit43 not uncached", 64'h0000_0FFF_F000_0001, 1'b0, 2'd3, 1'b0, 31'd0, 4'h0,
          44'hFFF_F000_0000, 1'b0, 3'd0);
  endtask

  task automatic testPhys();
    xlate("R4 phys passthrough", 64'h0000_0123_4567_89AA, 1'b1, 2'd3, 1'b0, 31'd0, 4'h0,
          44'h123_4567_89AA, 1'b0, 3'd0);
    xlate("R11 phys machine check", 64'h0000_1000_0000_0000, 1'b1, 2'd0, 1'b1, 31'd0, 4'hF,
          44'h0, 1'b0, 3'd3);
    xlate("R12 phys uncached", 64'h0000_0800_0000_0040, 1'b1, 2'd0, 1'b0, 31'd0, 4'h0,
          44'h800_0000_0040, 1'b1, 3'd0);
    xlate("R12 phys register space", 64'h0000_0FFF_F000_0000, 1'b1, 2'd0, 1'b0, 31'd0, 4'h0,
          44'h0, 1'b0, 3'd4);
  endtask

  task automatic testCanonical();
    xlate("R5 noncanonical", 64'h0001_0000_0000_0000, 1'b0, 2'd0, 1'b1, 31'h55, 4'hF,
          44'h0, 1'b0, 3'd1);
  endtask

  task automatic testSuper();
    xlate("R7 super kernel low", 64'hFFFF_FC12_3456_7890, 1'b0, 2'd0, 1'b0, 31'd0, 4'h0,
          44'h012_3456_7890, 1'b0, 3'd0);
    xlate("R7 super bit40 extends", 64'hFFFF_FD00_0000_1000, 1'b0, 2'd0, 1'b0, 31'd0, 4'h0,
          44'hF00_0000_1000, 1'b1, 3'd0);
    xlate("R6 super user", 64'hFFFF_FC12_3456_7890, 1'b0, 2'd3, 1'b1, 31'd1, 4'hF,
          44'h0, 1'b0, 3'd1);
    xlate("R6 super executive", 64'hFFFF_FC00_0000_0100, 1'b0, 2'd1, 1'b1, 31'd1, 4'hF,
          44'h0, 1'b0, 3'd1);
    xlate("R12 super register space", 64'hFFFF_FDFF_F000_0000, 1'b0, 2'd0, 1'b0, 31'd0, 4'h0,
          44'h0, 1'b0, 3'd4);
  endtask

  task automatic testTlb();
    xlate("R9 tlb hit", 64'h0000_0000_0040_3ABE, 1'b0, 2'd3, 1'b1, 31'h55, 4'hF,
          44'h0_000A_BABC, 1'b0, 3'd0);
    xlate("R8 tlb miss", 64'h0000_0000_0040_3ABE, 1'b0, 2'd0, 1'b0, 31'h55, 4'hF,
          44'h0, 1'b0, 3'd2);
    xlate("R10 tlb user denied", 64'h0000_0000_0040_3ABE, 1'b0, 2'd3, 1'b1, 31'h55, 4'b0111,
          44'h0, 1'b0, 3'd1);
    xlate("R10 tlb supervisor allowed", 64'h0000_0000_0040_3ABE, 1'b0, 2'd2, 1'b1, 31'h55, 4'b0111,
          44'h0_000A_BABC, 1'b0, 3'd0);
    xlate("R12 tlb uncached page", 64'hFFFF_FFFF_FFFF_E010, 1'b0, 2'd0, 1'b1, 31'h4000_0000, 4'h1,
          44'h800_0000_0010, 1'b1, 3'd0);
  endtask

  task automatic testLatency();
    @(negedge clk);
    chk("R2 idle no response", 64'(rspValid), 64'd0);
    xlate("R2 single response", 64'h0000_0000_0000_0101, 1'b0, 2'd0, 1'b0, 31'd0, 4'h0,
          44'h100, 1'b0, 3'd0);
    @(negedge clk);
    chk("R2 response lasts one cycle", 64'(rspValid), 64'd0);
  endtask

  initial begin
    testReset();
    testPal();
    testPhys();
    testCanonical();
    testSuper();
    testTlb();
    testLatency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule